// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave (Strobed Line Model)

This block is the slave end of a simple two-wire serial EEPROM holding a read-only image of up to 256 bytes. It does not run off the serial clock. A host moves the clock and data lines one step at a time, for example by writing a register, and presents each new pair of line levels with a one-cycle strobe. On every strobe the block compares the new levels with the levels it recorded on the previous strobe. From that comparison it finds bus conditions and clock edges.

A START begins a transaction. A single tick counter then steps through eight control bits and eight address bits, in that order. Each byte is followed by an acknowledge clock on which the slave pulls data low. When the last address bit is taken, the byte at that address is loaded into a data register. If the control byte ends in a 1, the next transaction sends that byte out MSB-first during its own address phase. The block's only output is the data level it recorded last. The host reads this level back as the slave's data line.

Top module: `ee2w_slave`

## Requirements
- R1: A strobe that keeps SCL high while SDA falls from 1 to 0 is a START. It puts the tick counter at its first control position and clears the control register, which abandons any transaction in progress.
- R2: While the tick counter is zero and no acknowledge is pending, every rising SCL edge is ignored until a START.
- R3: A bit is taken on a rising SCL edge only if SDA equals its recorded value. If SDA changes on the same strobe as SCL rises, no bit is taken and the counter does not move.
- R4: Eight control bits are shifted in MSB first, and the recorded SDA echoes the host level on each of them. After the eighth bit an acknowledge is pending. The next rising SCL edge records SDA as 0 whatever the host drives, and it takes no bit.
- R5: Eight address bits follow the control acknowledge. After the eighth, an acknowledge is pending and the counter returns to zero. Once that acknowledge clock is done, rising edges are ignored again (R2) and the host level is recorded.
- R6: If bit 0 of the control byte is 1, each address-phase rising edge records the MSB of the data register instead of the host level, and the register then shifts left. A byte loaded by the previous completed transaction therefore comes out MSB first.
- R7: If bit 0 of the control byte is 0, each address-phase rising edge records the host level.
- R8: A strobe that keeps SCL high while SDA rises from 0 to 1 is a STOP. It records SDA as 1 and leaves the counter and the pending bytes as they were.
- R9: The output is the SDA level recorded by the most recent strobe. It is 1 after reset and does not change on cycles without a strobe.
- R10: At the end of the address byte, the data register loads byte i of the parameter image, bits [8i+7:8i], where i is the address just received. Addresses at or beyond the configured depth read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe: the line levels below are a new sample |
| scl_lvl | input | 1 | Sampled serial clock level |
| sda_lvl | input | 1 | Sampled serial data level driven by the host |
| sda_seen | output | 1 | Recorded serial data level, including the slave's drive |

## Verification
Every strobe goes through exactly one register stage: the clock edge that accepts a strobe also updates the recorded SDA level. The new output value is therefore due on the cycle right after the strobe. The bench drives each strobe on a falling clock edge and drops it on the next falling edge. It then lets one idle cycle pass and samples the output on a falling edge, which also checks that nothing changes while no strobe is present. Expected values come from a per-bit account of the transaction. Acknowledge positions, echoed bits, read-out bits and the image byte are all derived from the requirements and the arithmetic image function.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;

   // Line event classified from one strobe against the recorded levels
   typedef enum logic [2:0] {
      EV_NONE     = 3'd0,
      EV_START    = 3'd1,
      EV_STOP     = 3'd2,
      EV_RISE_OK  = 3'd3,
      EV_RISE_BAD = 3'd4
   } ee2w_ev_e;

endpackage

// File: rtl/ee2w_line_watch.sv
module ee2w_line_watch
   import ee2w_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     smp_valid,
   input  logic     scl_lvl,
   input  logic     sda_lvl,
   input  logic     sda_rec_nxt,
   output ee2w_ev_e ev,
   output logic     sda_rec
);

   logic scl_rec;

   // Classify the new levels against the recorded pair
   always_comb begin
      ev = EV_NONE;
      if (scl_rec && scl_lvl && (sda_rec != sda_lvl)) begin
         ev = sda_lvl ? EV_STOP : EV_START;
      end else if (!scl_rec && scl_lvl) begin
         ev = (sda_lvl == sda_rec) ? EV_RISE_OK : EV_RISE_BAD;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_rec <= 1'b1;
         sda_rec <= 1'b1;
      end else if (smp_valid) begin
         scl_rec <= scl_lvl;
         sda_rec <= sda_rec_nxt;
      end
   end

   // R8: a stop records a high data level
   a_r8_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ev == EV_STOP) |=> sda_rec);

endmodule

// File: rtl/ee2w_rom.sv
module ee2w_rom #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256,
   parameter logic [DEPTH*DATA_W-1:0] IMAGE = '0
) (
   input  logic [ADDR_W-1:0] idx,
   output logic [DATA_W-1:0] rd_byte
);

   localparam int FULL = 1 << ADDR_W;

   generate
      if (DEPTH == FULL) begin : g_full
         always_comb rd_byte = IMAGE[int'(idx)*DATA_W +: DATA_W];
      end else begin : g_part
         always_comb begin
            rd_byte = '0;
            if (int'(idx) < DEPTH) rd_byte = IMAGE[int'(idx)*DATA_W +: DATA_W];
         end
      end
   endgenerate

endmodule

// File: rtl/ee2w_bit_seq.sv
module ee2w_bit_seq
   import ee2w_pkg::*;
#(
   parameter int CTRL_W = 8,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  ee2w_ev_e          ev,
   input  logic              sda_lvl,
   input  logic [DATA_W-1:0] rom_byte,
   output logic [ADDR_W-1:0] rom_idx,
   output logic              sda_rec_nxt,
   output logic              ack_pend
);

   localparam int LAST   = CTRL_W + ADDR_W + 1;
   localparam int TICK_W = $clog2(LAST + 1);
   localparam logic [TICK_W-1:0] T_ZERO     = '0;
   localparam logic [TICK_W-1:0] T_FIRST    = TICK_W'(1);
   localparam logic [TICK_W-1:0] T_CTRL_END = TICK_W'(CTRL_W + 1);
   localparam logic [TICK_W-1:0] T_ADDR_END = TICK_W'(LAST);

   logic [TICK_W-1:0] tick, tick_n;
   logic [CTRL_W-1:0] ctrl, ctrl_n;
   logic [ADDR_W-1:0] addr, addr_n;
   logic [DATA_W-1:0] data, data_n;
   logic              ack_n;

   assign rom_idx = ADDR_W'({addr, sda_lvl});

   always_comb begin
      tick_n      = tick;
      ctrl_n      = ctrl;
      addr_n      = addr;
      data_n      = data;
      ack_n       = ack_pend;
      sda_rec_nxt = sda_lvl;
      if (ev == EV_START) begin
         tick_n = T_FIRST;
         ctrl_n = '0;
      end else if (ev == EV_STOP) begin
         tick_n = tick;
      end else if (tick == T_ZERO && !ack_pend) begin
         tick_n = tick;
      end else if (ev == EV_RISE_OK || ev == EV_RISE_BAD) begin
         if (ack_pend) begin
            sda_rec_nxt = 1'b0;
            ack_n       = 1'b0;
         end else if (ev == EV_RISE_OK) begin
            if (tick < T_CTRL_END) begin
               ctrl_n = CTRL_W'({ctrl, sda_lvl});
               tick_n = tick + T_FIRST;
               if (tick == T_CTRL_END - T_FIRST) ack_n = 1'b1;
            end else if (tick < T_ADDR_END) begin
               if (ctrl[0]) sda_rec_nxt = data[DATA_W-1];
               addr_n = rom_idx;
               tick_n = tick + T_FIRST;
               data_n = data << 1;
               if (tick == T_ADDR_END - T_FIRST) begin
                  data_n = rom_byte;
                  ack_n  = 1'b1;
                  tick_n = T_ZERO;
               end
            end else begin
               sda_rec_nxt = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick     <= T_ZERO;
         ctrl     <= '0;
         addr     <= '0;
         data     <= '0;
         ack_pend <= 1'b0;
      end else if (smp_valid) begin
         tick     <= tick_n;
         ctrl     <= ctrl_n;
         addr     <= addr_n;
         data     <= data_n;
         ack_pend <= ack_n;
      end
   end

   // R1: start positions the counter and clears the control byte
   a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ev == EV_START) |=> (tick == T_FIRST && ctrl == '0));

   // R2: idle with no start leaves the shift state alone
   a_r2_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && tick == T_ZERO && !ack_pend && ev != EV_START)
      |=> (tick == T_ZERO && $stable(ctrl) && $stable(addr)));

   // R3: a rising edge with a changed data level takes no bit
   a_r3_bad_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ev == EV_RISE_BAD) |=> ($stable(tick) && $stable(ctrl) && $stable(addr)));

   // R5: the counter wraps to zero before passing the last address bit
   a_r5_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
      tick < T_ADDR_END);

endmodule

// File: rtl/ee2w_slave.sv
module ee2w_slave
   import ee2w_pkg::*;
#(
   parameter int CTRL_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int MEM_DEPTH = 256,
   parameter logic [MEM_DEPTH*DATA_W-1:0] INIT_IMAGE = '0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_valid,
   input  logic scl_lvl,
   input  logic sda_lvl,
   output logic sda_seen
);

   generate
      if (CTRL_W < 2) begin : g_bad_ctrl
         $error("ee2w_slave: CTRL_W must be at least 2");
      end
      if (ADDR_W < 2 || ADDR_W > 12) begin : g_bad_addr
         $error("ee2w_slave: ADDR_W must lie in 2..12");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("ee2w_slave: DATA_W must be positive");
      end
      if (MEM_DEPTH < 1 || MEM_DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("ee2w_slave: MEM_DEPTH must fit the address width");
      end
   endgenerate

   ee2w_ev_e          ev;
   logic              sda_rec_nxt;
   logic              ack_pend;
   logic [ADDR_W-1:0] rom_idx;
   logic [DATA_W-1:0] rom_byte;

   ee2w_line_watch u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .scl_lvl     (scl_lvl),
      .sda_lvl     (sda_lvl),
      .sda_rec_nxt (sda_rec_nxt),
      .ev          (ev),
      .sda_rec     (sda_seen)
   );

   ee2w_bit_seq #(
      .CTRL_W (CTRL_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .smp_valid   (smp_valid),
      .ev          (ev),
      .sda_lvl     (sda_lvl),
      .rom_byte    (rom_byte),
      .rom_idx     (rom_idx),
      .sda_rec_nxt (sda_rec_nxt),
      .ack_pend    (ack_pend)
   );

   ee2w_rom #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DEPTH  (MEM_DEPTH),
      .IMAGE  (INIT_IMAGE)
   ) u_rom (
      .idx     (rom_idx),
      .rd_byte (rom_byte)
   );

   // R9: no strobe, no change of the recorded level
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_valid |=> $stable(sda_seen));

   // R4: the clock edge that serves a pending acknowledge records a low level
   a_r4_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && ack_pend && (ev == EV_RISE_OK || ev == EV_RISE_BAD)) |=> !sda_seen);

endmodule

// File: tb/test_ee2w_slave.sv
`timescale 1ns/1ps
module test_ee2w_slave;

   function automatic logic [7:0] memb(int i);
      return 8'((i * 29 + 7) ^ (i >> 3));
   endfunction

   function automatic logic [2047:0] mk_img();
      logic [2047:0] img;
      for (int i = 0; i < 256; i++) img[i*8 +: 8] = memb(i);
      return img;
   endfunction

   localparam logic [2047:0] IMG = mk_img();

   logic clk = 1'b0;
   logic rst_n;
   logic smp_valid;
   logic scl_lvl;
   logic sda_lvl;
   logic sda_seen;
   int   n_run  = 0;
   int   n_fail = 0;
   logic [7:0] exp_data;

   always #2 clk = ~clk;

   ee2w_slave #(.INIT_IMAGE(IMG)) i_ee2w_slave (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .scl_lvl   (scl_lvl),
      .sda_lvl   (sda_lvl),
      .sda_seen  (sda_seen)
   );

   task automatic chk(logic exp, string tag);
      n_run++;
      if (sda_seen !== exp) begin
         n_fail++;
         $display("FAIL %s: sda_seen=%0b expected %0b", tag, sda_seen, exp);
      end
   endtask

   // One strobe; returns on a falling edge after the update and one idle cycle
   task automatic step(logic s, logic d);
      smp_valid = 1'b1;
      scl_lvl   = s;
      sda_lvl   = d;
      @(negedge clk);
      smp_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic send_bit(logic b, logic exp, string tag);
      step(1'b0, b);
      step(1'b1, b);
      chk(exp, tag);
      step(1'b0, b);
   endtask

   task automatic start_cond();
      step(1'b0, 1'b1);
      step(1'b1, 1'b1);
      step(1'b1, 1'b0);
   endtask

   task automatic stop_cond();
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      step(1'b1, 1'b1);
      chk(1'b1, "R8 stop records high");
   endtask

   task automatic ctrl_byte(logic [7:0] c);
      for (int i = 7; i >= 0; i--) send_bit(c[i], c[i], "R4 control bit echo");
   endtask

   task automatic tail(logic rw, logic [7:0] a);
      send_bit(1'b1, 1'b0, "R4 control ack");
      for (int i = 7; i >= 0; i--)
         send_bit(a[i], rw ? exp_data[i] : a[i], rw ? "R6 read-out bit" : "R7 write-mode echo");
      send_bit(1'b1, 1'b0, "R5 address ack");
      send_bit(1'b1, 1'b1, "R5 idle after address ack");
      exp_data = memb(int'(a)); // R10: loaded byte comes from the image
      stop_cond();
   endtask

   task automatic full_tx(logic rw, logic [7:0] a);
      start_cond();
      ctrl_byte({7'h50, rw});
      tail(rw, a);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      smp_valid = 1'b0;
      scl_lvl   = 1'b1;
      sda_lvl   = 1'b1;
      exp_data  = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(1'b1, "R9 reset level");

      // R9: levels change without a strobe
      scl_lvl = 1'b0;
      sda_lvl = 1'b0;
      repeat (3) @(negedge clk);
      chk(1'b1, "R9 no strobe no change");

      // R2: clocking before any start is ignored (no acknowledge appears)
      for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b1, "R2 ignored before start");

      // First read right after reset returns the cleared data register
      full_tx(1'b1, 8'h3C);

      // R1: a start in the middle of a control byte restarts the count
      start_cond();
      send_bit(1'b1, 1'b1, "R1 partial bit");
      send_bit(1'b0, 1'b0, "R1 partial bit");
      send_bit(1'b1, 1'b1, "R1 partial bit");
      send_bit(1'b1, 1'b1, "R1 partial bit");
      start_cond();
      ctrl_byte(8'hA1);
      tail(1'b1, 8'hC3);

      // R3: a data change on the rising edge takes no bit
      start_cond();
      for (int i = 7; i >= 1; i--) send_bit(8'hA1 >> i, 1'((8'hA1 >> i)), "R3 bit before glitch");
      step(1'b0, 1'b0);
      step(1'b1, 1'b1);
      chk(1'b1, "R3 glitch level recorded");
      step(1'b0, 1'b1);
      send_bit(1'b1, 1'b1, "R3 glitch not counted");
      tail(1'b1, 8'h5A);

      // R8: a stop mid-byte leaves the bit count untouched
      start_cond();
      send_bit(1'b1, 1'b1, "R8 bit before stop");
      send_bit(1'b0, 1'b0, "R8 bit before stop");
      send_bit(1'b1, 1'b1, "R8 bit before stop");
      step(1'b0, 1'b0);
      step(1'b1, 1'b0);
      chk(1'b0, "R8 bit before stop");
      step(1'b1, 1'b1);
      chk(1'b1, "R8 mid-byte stop records high");
      step(1'b0, 1'b1);
      send_bit(1'b0, 1'b0, "R8 bit after stop");
      send_bit(1'b0, 1'b0, "R8 bit after stop");
      send_bit(1'b0, 1'b0, "R8 bit after stop");
      send_bit(1'b1, 1'b1, "R8 bit after stop");
      tail(1'b1, 8'h81);

      // R6 R7 R10: sweep every address, mixing read and write modes
      for (int a = 0; a < 256; a++) full_tx((a % 3) != 0, 8'(a));
      full_tx(1'b1, 8'h00);

      summary();
      $finish;
   end

endmodule